// File: doc/BRIEF.md
# Port Control Register with Set/Clear Access and Reset Sequencing

This block holds the control word of one storage port. Software changes it through two write addresses. A write to the set address turns on every writable bit that is 1 in the data. A write to the clear address turns off every writable bit that is 1 in the data. A read at the set address returns the status word. That word is the stored controls with a ready flag in its top bit. Because each bit is changed through its own address, software never needs a read-modify-write, so no other writer's bits are disturbed.

The register also sequences the two reset controls. Port reset comes out of power-on reset asserted and stays on until software clears it. Device reset clears itself once a fixed count of clock cycles has passed. The ready flag is low while either reset is pending. It comes back a programmable number of cycles after both resets are done and the link is reported up.

The link, PHY and command engine are outside this block. They are seen only through the `link_up_i` input and the `ready_o` output.

Top module: `port_ctl_regs`

## Requirements
- R1: A write to SET_ADDR (default 0x1000) sets every writable bit that is 1 in `wdata_i` and leaves every other bit unchanged. The writable bits are: bit 0 port reset, bit 1 device reset, bit 2 initialize, bit 3 interrupt write-one-to-clear mode, bit 6 resume, bit 10 32-bit activation, bit 13 multiplier enable.
- R2: A write to CLR_ADDR (default 0x1004) clears every writable bit that is 1 in `wdata_i` and leaves every other bit unchanged.
- R3: `rdata_o` is combinational. At SET_ADDR it returns the stored control bits, with bit 31 equal to `ready_o`. At any other address, CLR_ADDR included, it returns 0.
- R4: After reset the status word reads 0x0000_0001: port reset is 1 and ready is 0. Port reset keeps its value until software clears it.
- R5: Suppose device reset is set at clock edge E and software does not touch it again. It reads 1 after edges E through E+DRST_CYCLES-1 and reads 0 after edge E+DRST_CYCLES.
- R6: `ready_o` is 0 after any edge at which port reset or device reset holds 1. This includes the edge at which either reset bit becomes 1.
- R7: Let L be the first edge at which both reset bits end up 0 and `link_up_i` is high. `ready_o` becomes 1 at edge L+RDY_DELAY. Any edge at which `link_up_i` is low sets `ready_o` to 0 and restarts the count.
- R8: Bits 4, 5, 7-9, 11, 12 and 14-30 are reserved. They read 0, and set and clear writes do not change them. Bit 31 is also unaffected by set and clear writes.
- R9: A write to any address other than SET_ADDR and CLR_ADDR changes no bit.
- R10: A software set of device reset may land on the same edge as the self-clear of device reset. In that case the clear wins, and device reset reads 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| wr_i | input | 1 | Write strobe, one write per cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| link_up_i | input | 1 | Link is established |
| ready_o | output | 1 | Port can accept commands |

## Verification
The hardest case to reach is the R10 collision. A software set of device reset has to land on exactly the edge where the internal timer expires. The bench counts DRST_CYCLES-1 cycles from the first set of device reset and then issues a second set write, so that its edge lines up with the expiry.

The ready restart is the other timing-sensitive point. The bench checks the cycle one before and the cycle of the ready rise, in three cases: after a software port-reset clear, after device-reset expiry, and after link-up returns.

// File: rtl/port_ctl_pkg.sv
package port_ctl_pkg;
  localparam int unsigned DATA_W = 32;

  localparam int unsigned B_PRST  = 0;
  localparam int unsigned B_DRST  = 1;
  localparam int unsigned B_INIT  = 2;
  localparam int unsigned B_WOC   = 3;
  localparam int unsigned B_RSUM  = 6;
  localparam int unsigned B_ACT32 = 10;
  localparam int unsigned B_PMEN  = 13;
  localparam int unsigned B_RDY   = 31;

  localparam logic [DATA_W-1:0] WR_MASK =
      (DATA_W'(1) << B_PRST)  | (DATA_W'(1) << B_DRST) | (DATA_W'(1) << B_INIT) |
      (DATA_W'(1) << B_WOC)   | (DATA_W'(1) << B_RSUM) | (DATA_W'(1) << B_ACT32) |
      (DATA_W'(1) << B_PMEN);

  localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(1) << B_PRST;
endpackage

// File: rtl/port_ctl_bank.sv
module port_ctl_bank
  import port_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] q_o,
  output logic              rst_next_o
);
  logic [DATA_W-1:0] d;

  // clear applied after set: clear wins on collision
  assign d = ((q_o | set_i) & ~clr_i) & WR_MASK;
  assign rst_next_o = d[B_PRST] | d[B_DRST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= d;
  end
endmodule

// File: rtl/port_ctl_drst_tmr.sv
module port_ctl_drst_tmr #(
  parameter int unsigned DRST_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic expire_o
);
  localparam int unsigned CW = (DRST_CYCLES > 1) ? $clog2(DRST_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DRST_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = active_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!active_i || expire_o) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/port_ctl_rdy_seq.sv
module port_ctl_rdy_seq #(
  parameter int unsigned RDY_DELAY = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(RDY_DELAY + 1) > 0 ? $clog2(RDY_DELAY + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(RDY_DELAY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_o <= 1'b0;
    end else if (busy_i) begin
      cnt_q   <= '0;
      ready_o <= 1'b0;
    end else if (!ready_o) begin
      if (cnt_q == LAST) ready_o <= 1'b1;
      else               cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/port_ctl_regs.sv
module port_ctl_regs
  import port_ctl_pkg::*;
#(
  parameter int unsigned          ADDR_W      = 13,
  parameter logic [ADDR_W-1:0]    SET_ADDR    = 13'h1000,
  parameter logic [ADDR_W-1:0]    CLR_ADDR    = 13'h1004,
  parameter int unsigned          DRST_CYCLES = 64,
  parameter int unsigned          RDY_DELAY   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              link_up_i,
  output logic              ready_o
);
  logic              wr_set, wr_clr, drst_exp, rst_next;
  logic [DATA_W-1:0] set_vec, clr_vec, ctrl_q, status;

  assign wr_set  = wr_i && (addr_i == SET_ADDR);
  assign wr_clr  = wr_i && (addr_i == CLR_ADDR);
  assign set_vec = wr_set ? wdata_i : '0;
  assign clr_vec = (wr_clr ? wdata_i : '0) | (drst_exp ? (DATA_W'(1) << B_DRST) : '0);

  port_ctl_bank u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_vec),
    .clr_i      (clr_vec),
    .q_o        (ctrl_q),
    .rst_next_o (rst_next)
  );

  port_ctl_drst_tmr #(.DRST_CYCLES(DRST_CYCLES)) u_drst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (ctrl_q[B_DRST]),
    .expire_o (drst_exp)
  );

  port_ctl_rdy_seq #(.RDY_DELAY(RDY_DELAY)) u_rdy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (rst_next || !link_up_i),
    .ready_o (ready_o)
  );

  assign status  = ctrl_q | (ready_o ? (DATA_W'(1) << B_RDY) : '0);
  assign rdata_o = (addr_i == SET_ADDR) ? status : '0;
endmodule

// File: rtl/port_ctl_regs_chk.sv
module port_ctl_regs_chk #(
  parameter int unsigned       ADDR_W      = 13,
  parameter logic [ADDR_W-1:0] SET_ADDR    = 13'h1000,
  parameter logic [ADDR_W-1:0] CLR_ADDR    = 13'h1004,
  parameter int unsigned       DRST_CYCLES = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              wdata_prst,
  input logic              wdata_woc,
  input logic              link_up_i,
  input logic              ready_o,
  input logic              prst_q,
  input logic              drst_q,
  input logic              woc_q
);
  localparam int unsigned CW = $clog2(DRST_CYCLES + 2);
  localparam logic [CW-1:0] LIM = CW'(DRST_CYCLES);

  logic [CW-1:0] hi_cnt;
  logic          set_wr, clr_wr;

  assign set_wr = wr_i && (addr_i == SET_ADDR);
  assign clr_wr = wr_i && (addr_i == CLR_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            hi_cnt <= '0;
    else if (!drst_q)       hi_cnt <= '0;
    else if (hi_cnt != '1)  hi_cnt <= hi_cnt + 1'b1;
  end

  AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_wr && wdata_woc) |=> woc_q); // R1
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && wdata_prst) |=> !prst_q); // R2
  AST_PRST_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prst_q && !(clr_wr && wdata_prst)) |=> prst_q); // R4
  AST_DRST_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drst_q |-> (hi_cnt < LIM)); // R5
  AST_RDY_NOT_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!prst_q && !drst_q)); // R6
  AST_RDY_NEEDS_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(link_up_i)); // R7
endmodule

bind port_ctl_regs port_ctl_regs_chk #(
  .ADDR_W(ADDR_W), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR), .DRST_CYCLES(DRST_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .wdata_prst (wdata_i[0]),
  .wdata_woc  (wdata_i[3]),
  .link_up_i  (link_up_i),
  .ready_o    (ready_o),
  .prst_q     (ctrl_q[0]),
  .drst_q     (ctrl_q[1]),
  .woc_q      (ctrl_q[3])
);

// File: tb/port_ctl_regs_tb_top.sv
module port_ctl_regs_tb_top;
  localparam int unsigned ADDR_W = 13;
  localparam logic [ADDR_W-1:0] SA = 13'h1000;
  localparam logic [ADDR_W-1:0] CA = 13'h1004;
  localparam logic [ADDR_W-1:0] OA = 13'h1008;
  localparam int unsigned DRST = 20;
  localparam int unsigned RDY  = 4;

  // {op, data, expected status}; op 0 set, 1 clear, 2 write elsewhere
  localparam int NV = 9;
  localparam logic [65:0] VEC [NV] = '{
    {2'd0, 32'h0000_0004, 32'h8000_0004},  // R1
    {2'd0, 32'h0000_2408, 32'h8000_240C},  // R1
    {2'd0, 32'hFFFF_FF30, 32'h8000_240C},  // R8
    {2'd0, 32'h0000_0040, 32'h8000_244C},  // R1
    {2'd1, 32'h0000_0408, 32'h8000_2044},  // R2
    {2'd1, 32'h8000_0000, 32'h8000_2044},  // R8
    {2'd2, 32'hFFFF_FFFF, 32'h8000_2044},  // R9
    {2'd1, 32'h0000_2004, 32'h8000_0040},  // R2
    {2'd1, 32'hFFFF_FFFF, 32'h8000_0000}   // R2
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = SA;
  logic              wr_i = 1'b0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic              link_up_i = 1'b1;
  logic              ready_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  port_ctl_regs #(.DRST_CYCLES(DRST), .RDY_DELAY(RDY)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .link_up_i(link_up_i), .ready_o(ready_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic do_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; addr_i = SA; wdata_i = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
    addr_i = a; #1; v = rdata_o; addr_i = SA; #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(SA, v); chk("R4 reset status", v, 32'h0000_0001);
    chk("R6 ready low in reset", {31'b0, ready_o}, 32'h0);
    repeat (10) @(negedge clk_i);
    rd(SA, v); chk("R4 port reset held", v, 32'h0000_0001);
    rd(CA, v); chk("R3 read at clear addr", v, 32'h0);

    do_wr(CA, 32'h1);
    rd(SA, v); chk("R2 port reset cleared", v, 32'h0);
    repeat (RDY - 1) @(negedge clk_i);
    chk("R7 ready before delay", {31'b0, ready_o}, 32'h0);
    @(negedge clk_i);
    chk("R7 ready after delay", {31'b0, ready_o}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [31:0] dd, ex;
      {op, dd, ex} = VEC[i];
      do_wr(op == 2'd0 ? SA : (op == 2'd1 ? CA : OA), dd);
      rd(SA, v); chk($sformatf("R1/R2/R8/R9 vector %0d", i), v, ex);
    end
    rd(OA, v); chk("R3 read elsewhere", v, 32'h0);

    do_wr(SA, 32'h2);
    rd(SA, v); chk("R5/R6 device reset set", v, 32'h0000_0002);
    repeat (DRST - 1) @(negedge clk_i);
    rd(SA, v); chk("R5 device reset still on", v, 32'h0000_0002);
    @(negedge clk_i);
    rd(SA, v); chk("R5 device reset self-clear", v, 32'h0);
    repeat (RDY - 1) @(negedge clk_i);
    chk("R7 ready before delay after drst", {31'b0, ready_o}, 32'h0);
    @(negedge clk_i);
    chk("R7 ready after drst", {31'b0, ready_o}, 32'h1);

    do_wr(SA, 32'h2);
    repeat (DRST - 1) @(negedge clk_i);
    do_wr(SA, 32'h2);
    rd(SA, v); chk("R10 clear wins on collision", v, 32'h0);
    repeat (RDY) @(negedge clk_i);
    chk("R7 ready after collision", {31'b0, ready_o}, 32'h1);

    link_up_i = 1'b0;
    @(negedge clk_i);
    chk("R7 ready drops on link down", {31'b0, ready_o}, 32'h0);
    rd(SA, v); chk("R7 status with link down", v, 32'h0);
    link_up_i = 1'b1;
    repeat (RDY) @(negedge clk_i);
    chk("R7 ready before delay after link", {31'b0, ready_o}, 32'h0);
    @(negedge clk_i);
    chk("R7 ready after link up", {31'b0, ready_o}, 32'h1);

    do_wr(SA, 32'h1);
    chk("R6 ready low on port reset", {31'b0, ready_o}, 32'h0);
    repeat (30) @(negedge clk_i);
    rd(SA, v); chk("R4 software port reset held", v, 32'h0000_0001);
    do_wr(CA, 32'h1);
    repeat (RDY) @(negedge clk_i);
    rd(SA, v); chk("R3/R7 status ready", v, 32'h8000_0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule